// File: doc/BRIEF.md
# Dual-Bound Output Clamp Limiter

This block sits at the output of an image filter and holds every 12-bit result sample between a programmable floor and a programmable ceiling. It keeps a bank of four floor/ceiling pairs. Each output lane picks one pair on every clock through a 2-bit set index. Interleaved streams, such as multi-component video where luma and chroma samples alternate, can therefore give each component its own range without reprogramming between samples.

There are two lanes, one for the vertical filter result and one for the horizontal result. Limiting can be switched on or off per lane. Each lane has one register stage, so its latency is the same whether limiting is on or off. A small register-write port programs the bounds and the control bits. A gating control can restrict bound updates to cycles in which the shift enable is active, so that new bounds land in step with the data flow. A configuration-error output is high whenever any stored pair has a ceiling that is not above its floor.

Top module: `dual_bound_clamp`

## Requirements
- R1: While reset is asserted and after it is released, both results and cfg_err are 0. Every pair holds floor 0 and ceiling 4095. Limiting is off for both lanes and gating is off.
- R2: A write happens on a rising clock edge when wr_en is 1. Address k (0 to 3) is the floor of set k. Address 4+k is the ceiling of set k. Address 8 is the limit enable register: bit 0 is the vertical lane and bit 1 is the horizontal lane. Address 9 is the gating register, bit 0.
- R3: With limiting on, a sample above the selected ceiling yields the ceiling and a sample below the selected floor yields the floor. A sample equal to a bound, or between the bounds, passes unchanged.
- R4: Each lane uses the pair named by its own set index in that cycle. The index may change on every clock.
- R5: A result appears exactly one clock after its sample, with limiting on or off. With limiting off, the result equals the sample.
- R6: The vertical and horizontal enable bits act independently, each on its own lane only.
- R7: With gating on, a floor or ceiling write takes effect only if shift_en is 1 in the write cycle, and is discarded otherwise. With gating off, bound writes always take effect. The control registers are always writable.
- R8: cfg_err is 1 from the clock edge after a write that leaves any pair with ceiling less than or equal to floor. It is 0 while every pair has ceiling above floor.
- R9: For a pair with ceiling at or below floor, the ceiling test is applied first: a sample above the ceiling yields the ceiling, otherwise a sample below the floor yields the floor.
- R10: Bits 11 to 2 of the enable register, bits 11 to 1 of the gating register, and writes to addresses 10 to 15 have no effect.
- R11: A sample presented in the same cycle as a bound write is clamped against the bounds held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 12 | Register write value |
| shift_en | input | 1 | Shift enable used to gate bound writes |
| v_sample | input | 12 | Vertical lane input sample |
| v_set | input | 2 | Vertical lane bound-pair index |
| h_sample | input | 12 | Horizontal lane input sample |
| h_set | input | 2 | Horizontal lane bound-pair index |
| v_result | output | 12 | Vertical lane clamped result |
| h_result | output | 12 | Horizontal lane clamped result |
| cfg_err | output | 1 | A stored pair has ceiling not above floor |

## Verification
Some rules are checked on every cycle. A limited lane with a well-formed pair never leaves that pair's range. A bypassed lane repeats its previous sample. Bounds stay unchanged when gating is on and shift enable is low. The error flag always matches the stored pairs. The directed scenarios cover the rest. They show the exact clamp values at and beyond each bound, the per-clock switching between four different ranges, and the priority rule for malformed pairs. They also show that writes landing in the same cycle as a sample are ignored by that sample, and that reserved bits and unmapped addresses change nothing.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
    localparam int DATA_W    = 12;
    localparam int NUM_SETS  = 4;
    localparam int NUM_LANES = 2;
    localparam int SEL_W     = $clog2(NUM_SETS);
    localparam int ADDR_W    = $clog2(2 * NUM_SETS + 2);
    localparam int LANE_V    = 0;
    localparam int LANE_H    = 1;

    typedef logic [DATA_W-1:0] sample_t;
    typedef logic [SEL_W-1:0]  set_idx_t;

    typedef struct packed {
        sample_t lo;
        sample_t hi;
    } bound_pair_t;

    typedef bound_pair_t [NUM_SETS-1:0] bound_bank_t;

    // Ceiling test first, so a malformed pair resolves deterministically.
    function automatic sample_t clamp_value(input sample_t s, input bound_pair_t p);
        if (s > p.hi)      return p.hi;
        else if (s < p.lo) return p.lo;
        else               return s;
    endfunction

    function automatic logic pair_bad(input bound_pair_t p);
        return p.hi <= p.lo;
    endfunction
endpackage

// File: rtl/clamp_cfg_regs.sv
module clamp_cfg_regs
    import clamp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  sample_t              wr_data,
    input  logic                 shift_en,
    output bound_bank_t          bounds,
    output logic [NUM_LANES-1:0] lim_ena,
    output logic                 load_gate,
    output logic                 cfg_err
);
    localparam int LO_BASE   = 0;
    localparam int HI_BASE   = NUM_SETS;
    localparam int ENA_ADDR  = 2 * NUM_SETS;
    localparam int GATE_ADDR = ENA_ADDR + 1;

    typedef struct packed {
        bound_bank_t          bank;
        logic [NUM_LANES-1:0] ena;
        logic                 gate;
        logic                 err;
    } cfg_state_t;

    function automatic cfg_state_t reset_state();
        cfg_state_t r;
        r = '0;
        for (int k = 0; k < NUM_SETS; k++) begin
            r.bank[k].lo = '0;
            r.bank[k].hi = '1;
        end
        return r;
    endfunction

    cfg_state_t st_d, st_q;
    logic       bound_wr_ok;
    logic       bad_acc;

    always_comb begin
        st_d        = st_q;
        bound_wr_ok = !st_q.gate || shift_en;
        if (wr_en) begin
            for (int k = 0; k < NUM_SETS; k++) begin
                if (bound_wr_ok && wr_addr == ADDR_W'(LO_BASE + k))
                    st_d.bank[k].lo = wr_data;
                if (bound_wr_ok && wr_addr == ADDR_W'(HI_BASE + k))
                    st_d.bank[k].hi = wr_data;
            end
            if (wr_addr == ADDR_W'(ENA_ADDR))
                st_d.ena = wr_data[NUM_LANES-1:0];
            if (wr_addr == ADDR_W'(GATE_ADDR))
                st_d.gate = wr_data[0];
        end
        bad_acc = 1'b0;
        for (int k = 0; k < NUM_SETS; k++)
            bad_acc = bad_acc | pair_bad(st_d.bank[k]);
        st_d.err = bad_acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign bounds    = st_q.bank;
    assign lim_ena   = st_q.ena;
    assign load_gate = st_q.gate;
    assign cfg_err   = st_q.err;
endmodule

// File: rtl/clamp_lane.sv
module clamp_lane
    import clamp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  sample_t     din,
    input  set_idx_t    sel,
    input  bound_bank_t bounds,
    input  logic        limit_on,
    output sample_t     dout
);
    typedef struct packed {
        sample_t res;
    } lane_state_t;

    lane_state_t st_d, st_q;
    bound_pair_t picked;

    always_comb begin
        st_d   = st_q;
        picked = bounds[sel];
        if (limit_on) st_d.res = clamp_value(din, picked);
        else          st_d.res = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.res;
endmodule

// File: rtl/dual_bound_clamp.sv
module dual_bound_clamp
    import clamp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              shift_en,
    input  logic [DATA_W-1:0] v_sample,
    input  logic [SEL_W-1:0]  v_set,
    input  logic [DATA_W-1:0] h_sample,
    input  logic [SEL_W-1:0]  h_set,
    output logic [DATA_W-1:0] v_result,
    output logic [DATA_W-1:0] h_result,
    output logic              cfg_err
);
    bound_bank_t          bounds_w;
    logic [NUM_LANES-1:0] lim_ena_w;
    logic                 load_gate_w;
    sample_t              lane_in  [NUM_LANES];
    set_idx_t             lane_sel [NUM_LANES];
    sample_t              lane_out [NUM_LANES];

    clamp_cfg_regs cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .shift_en  (shift_en),
        .bounds    (bounds_w),
        .lim_ena   (lim_ena_w),
        .load_gate (load_gate_w),
        .cfg_err   (cfg_err)
    );

    assign lane_in[LANE_V]  = v_sample;
    assign lane_sel[LANE_V] = v_set;
    assign lane_in[LANE_H]  = h_sample;
    assign lane_sel[LANE_H] = h_set;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        clamp_lane lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .din      (lane_in[g]),
            .sel      (lane_sel[g]),
            .bounds   (bounds_w),
            .limit_on (lim_ena_w[g]),
            .dout     (lane_out[g])
        );
    end

    assign v_result = lane_out[LANE_V];
    assign h_result = lane_out[LANE_H];
endmodule

// File: rtl/clamp_checker.sv
module clamp_checker
    import clamp_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 shift_en,
    input logic [DATA_W-1:0]    v_sample,
    input logic [SEL_W-1:0]     v_set,
    input logic [DATA_W-1:0]    h_sample,
    input logic [SEL_W-1:0]     h_set,
    input logic [DATA_W-1:0]    v_result,
    input logic [DATA_W-1:0]    h_result,
    input logic                 cfg_err,
    input bound_bank_t          bounds,
    input logic [NUM_LANES-1:0] lim_ena,
    input logic                 load_gate
);
    logic any_bad;
    always_comb begin
        any_bad = 1'b0;
        for (int k = 0; k < NUM_SETS; k++)
            any_bad = any_bad | (bounds[k].hi <= bounds[k].lo);
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (v_result == '0 && h_result == '0 && !cfg_err));

    a_r3_v_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_ena[LANE_V] && bounds[v_set].hi > bounds[v_set].lo)
        |=> (v_result >= $past(bounds[v_set].lo) && v_result <= $past(bounds[v_set].hi)));

    a_r3_h_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_ena[LANE_H] && bounds[h_set].hi > bounds[h_set].lo)
        |=> (h_result >= $past(bounds[h_set].lo) && h_result <= $past(bounds[h_set].hi)));

    a_r5_v_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !lim_ena[LANE_V] |=> v_result == $past(v_sample));

    a_r5_h_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !lim_ena[LANE_H] |=> h_result == $past(h_sample));

    a_r7_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_gate && !shift_en) |=> $stable(bounds));

    a_r8_err_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err == any_bad);
endmodule

bind dual_bound_clamp clamp_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .v_sample  (v_sample),
    .v_set     (v_set),
    .h_sample  (h_sample),
    .h_set     (h_set),
    .v_result  (v_result),
    .h_result  (h_result),
    .cfg_err   (cfg_err),
    .bounds    (bounds_w),
    .lim_ena   (lim_ena_w),
    .load_gate (load_gate_w)
);

// File: tb/dual_bound_clamp_tb.sv
module dual_bound_clamp_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [11:0] wr_data;
    logic        shift_en;
    logic [11:0] v_sample, h_sample;
    logic [1:0]  v_set, h_set;
    logic [11:0] v_result, h_result;
    logic        cfg_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [11:0] m_lo [4];
    logic [11:0] m_hi [4];
    logic [1:0]  m_ena;
    logic        m_gate;

    always #5 clk = ~clk;

    dual_bound_clamp dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .shift_en(shift_en),
        .v_sample(v_sample), .v_set(v_set), .h_sample(h_sample), .h_set(h_set),
        .v_result(v_result), .h_result(h_result), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [11:0] model(input logic [11:0] s, input int lane, input logic [1:0] sel);
        if (!m_ena[lane])      return s;
        if (s > m_hi[sel])     return m_hi[sel];
        if (s < m_lo[sel])     return m_lo[sel];
        return s;
    endfunction

    function automatic logic model_err();
        for (int k = 0; k < 4; k++)
            if (m_hi[k] <= m_lo[k]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_write(input logic [3:0] a, input logic [11:0] d, input logic se);
        if (a < 4) begin
            if (!m_gate || se) m_lo[a[1:0]] = d;
        end else if (a < 8) begin
            if (!m_gate || se) m_hi[a[1:0]] = d;
        end else if (a == 8) m_ena = d[1:0];
        else if (a == 9)     m_gate = d[0];
    endtask

    // Tasks start and end at a falling edge.
    task automatic write_reg(input logic [3:0] a, input logic [11:0] d, input logic se);
        wr_en = 1'b1; wr_addr = a; wr_data = d; shift_en = se;
        @(negedge clk);
        wr_en = 1'b0; shift_en = 1'b0;
        model_write(a, d, se);
    endtask

    task automatic apply(input string req, input logic [11:0] vs, input logic [1:0] vi,
                         input logic [11:0] hs, input logic [1:0] hi);
        logic [11:0] ev, eh;
        v_sample = vs; v_set = vi; h_sample = hs; h_set = hi;
        ev = model(vs, 0, vi);
        eh = model(hs, 1, hi);
        @(negedge clk);
        check({req, " v"}, int'(v_result), int'(ev));
        check({req, " h"}, int'(h_result), int'(eh));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; shift_en = 1'b0;
        v_sample = 12'd77; h_sample = 12'd88; v_set = '0; h_set = '0;
        for (int k = 0; k < 4; k++) begin m_lo[k] = 12'd0; m_hi[k] = 12'd4095; end
        m_ena = 2'b00; m_gate = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 v_result in reset", int'(v_result), 0);
        check("R1 h_result in reset", int'(h_result), 0);
        check("R1 cfg_err in reset", int'(cfg_err), 0);
        rst_n = 1'b1;
        check("R1 cfg_err after release", int'(cfg_err), 0);
        // Default pairs 0..4095: enabling limiting must not alter any value.
        write_reg(4'd8, 12'h003, 1'b0);
        apply("R1 default bounds", 12'd4095, 2'd3, 12'd0, 2'd1);
        write_reg(4'd8, 12'h000, 1'b0);
    endtask

    task automatic t_bypass();
        apply("R5 bypass hi", 12'd4000, 2'd0, 12'd5, 2'd2);
        apply("R5 bypass mid", 12'd1234, 2'd1, 12'd3210, 2'd3);
    endtask

    task automatic t_clamp_basic();
        write_reg(4'd0, 12'd100, 1'b0);   // R2 floor of set 0
        write_reg(4'd4, 12'd3000, 1'b0);  // R2 ceiling of set 0
        write_reg(4'd8, 12'h003, 1'b0);
        apply("R3 below", 12'd50, 2'd0, 12'd99, 2'd0);
        apply("R3 at bounds", 12'd100, 2'd0, 12'd3000, 2'd0);
        apply("R3 above", 12'd3001, 2'd0, 12'd4095, 2'd0);
        apply("R3 inside", 12'd2000, 2'd0, 12'd101, 2'd0);
    endtask

    task automatic t_interleave();
        write_reg(4'd1, 12'd200, 1'b0); write_reg(4'd5, 12'd400, 1'b0);
        write_reg(4'd2, 12'd1000, 1'b0); write_reg(4'd6, 12'd1100, 1'b0);
        write_reg(4'd3, 12'd16, 1'b0); write_reg(4'd7, 12'd240, 1'b0);
        for (int i = 0; i < 8; i++) begin
            apply("R4 interleave", 12'(i * 500 + 7), 2'(i), 12'(4000 - i * 480), 2'(3 - i));
        end
    endtask

    task automatic t_lane_enables();
        write_reg(4'd8, 12'h002, 1'b0);  // R6 horizontal only
        apply("R6 h only", 12'd3500, 2'd0, 12'd3500, 2'd0);
        write_reg(4'd8, 12'h001, 1'b0);  // R6 vertical only
        apply("R6 v only", 12'd10, 2'd1, 12'd10, 2'd1);
        write_reg(4'd8, 12'h003, 1'b0);
    endtask

    task automatic t_gate();
        write_reg(4'd9, 12'h001, 1'b0);
        write_reg(4'd1, 12'd900, 1'b0);  // R7 discarded
        apply("R7 gated drop", 12'd300, 2'd1, 12'd300, 2'd1);
        write_reg(4'd1, 12'd350, 1'b1);  // R7 accepted
        apply("R7 gated accept", 12'd300, 2'd1, 12'd360, 2'd1);
        write_reg(4'd8, 12'h000, 1'b0);  // R7 control still writable
        apply("R7 control writable", 12'd300, 2'd1, 12'd5, 2'd1);
        write_reg(4'd8, 12'h003, 1'b0);
        write_reg(4'd9, 12'h000, 1'b0);
        write_reg(4'd1, 12'd200, 1'b0);  // R7 ungated write lands
        apply("R7 ungated", 12'd250, 2'd1, 12'd150, 2'd1);
    endtask

    task automatic t_err_priority();
        write_reg(4'd2, 12'd1100, 1'b0); // R8 pair 2 equal
        check("R8 equal pair flags", int'(cfg_err), int'(model_err()));
        write_reg(4'd2, 12'd1500, 1'b0); // R9 floor 1500, ceiling 1100
        check("R8 inverted pair flags", int'(cfg_err), 1);
        apply("R9 above ceiling", 12'd1200, 2'd2, 12'd1050, 2'd2);
        write_reg(4'd2, 12'd1000, 1'b0);
        check("R8 cleared", int'(cfg_err), 0);
    endtask

    task automatic t_reserved();
        write_reg(4'd8, 12'hFFC, 1'b0);  // R10 bits 11:2 ignored, both lanes off
        apply("R10 enable reserved", 12'd4090, 2'd0, 12'd1, 2'd0);
        write_reg(4'd8, 12'h003, 1'b0);
        write_reg(4'd9, 12'hFFE, 1'b0);  // R10 gate stays off
        write_reg(4'd0, 12'd110, 1'b0);
        apply("R10 gate reserved", 12'd105, 2'd0, 12'd111, 2'd0);
        for (int a = 10; a < 16; a++) write_reg(4'(a), 12'd4095, 1'b0);
        apply("R10 unmapped", 12'd105, 2'd0, 12'd3500, 2'd0);
        check("R10 unmapped err", int'(cfg_err), 0);
    endtask

    task automatic t_same_cycle();
        logic [11:0] ev;
        ev = model(12'd50, 0, 2'd0);     // floor still 110
        wr_en = 1'b1; wr_addr = 4'd0; wr_data = 12'd20; shift_en = 1'b0;
        v_sample = 12'd50; v_set = 2'd0; h_sample = 12'd60; h_set = 2'd0;
        @(negedge clk);
        wr_en = 1'b0;
        check("R11 old bounds used", int'(v_result), int'(ev));
        model_write(4'd0, 12'd20, 1'b0);
        apply("R11 new bounds next", 12'd50, 2'd0, 12'd10, 2'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_clamp_basic();
        t_interleave();
        t_lane_enables();
        t_gate();
        t_err_priority();
        t_reserved();
        t_same_cycle();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule